// File: doc/BRIEF.md
# Dual-Modulus Programmable Frequency Divider

This block divides a clock derived from a voltage-controlled oscillator by a programmable ratio N and gives one pulse per N input cycles to a phase comparator. It does not use one wide down counter. A prescaler stage divides by 32 or by 33. A 5-bit swallow counter picks the modulus, and a 10-bit main counter counts prescaler cycles. The prescaler divides by 33 for the first A of its cycles and by 32 for the remaining M−A cycles, so each output period lasts 32·M + A = N input cycles. Here A is N[4:0] and M is N[14:5].

A 15-bit ratio is written with a load strobe and held in a pending register. The pending value takes effect only where one output period ends and the next begins, so a ratio change never produces a short or long period. Ratios below 1024 are raised to 1024. This guarantees M ≥ 32 > A, which the swallow scheme needs. With a divide-by-8 stage in front and a 3.90625 kHz comparison rate, each step of N moves the oscillator by 31.25 kHz.

Top module: `pswl_divider`

## Requirements
- R1: While `rst_n_i` is low, `div_pulse_o` is low. After reset release (two-stage synchroniser) the active ratio is RST_RATIO, which defaults to 1024. The first pulse follows the (RST_RATIO+2)-th rising edge after release.
- R2: Each output pulse is high for exactly one input clock cycle.
- R3: Consecutive output pulses are exactly N input cycles apart for any applied N from 1024 to 32767.
- R4: The prescaler stage lasts 33 input cycles for the first N[4:0] prescaler cycles of a period and 32 for the rest. Its terminal counts are therefore always 32 or 33 cycles apart. A=0 and A=31 both give the exact ratio.
- R5: `ratio_i` is captured only on a rising edge where `load_i` is high. Changes of `ratio_i` without a load have no effect on the output period.
- R6: A captured ratio becomes active at the first period boundary after capture. If the load is applied in the cycle where a pulse is high, the period then running completes with the old N, and every later period uses the new N.
- R7: A loaded value below 1024 (including 0) is treated as 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divided oscillator clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_i | input | 15 | Requested division ratio N |
| load_i | input | 1 | Capture strobe for `ratio_i` |
| div_pulse_o | output | 1 | One-cycle pulse per N input cycles |

## Verification
A wrong swallow or main counter value shows up only as a wrong spacing between pulses. The error is therefore visible at the end of the first affected period, up to N cycles later, as a gap off by a multiple of one cycle (swallow) or 32 cycles (main). A wrong pending or active ratio register shows as an off-by-one-period moment of change, or as a period that matches neither the old nor the new N. The bench therefore measures the gap on both sides of every load. It uses A=0, A=31 and the extreme ratios so that each modulus path and the counter widths are exercised.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  localparam int unsigned PSWL_SWALLOW_W = 5;
  localparam int unsigned PSWL_MAIN_W    = 10;

  // Prescaler modulus selection: base = 2**SWALLOW_W, extra = base + 1
  typedef enum logic {
    MOD_BASE  = 1'b0,
    MOD_EXTRA = 1'b1
  } pswl_mod_e;
endpackage

// File: rtl/pswl_ratio_stage.sv
module pswl_ratio_stage #(
  parameter int unsigned RATIO_W   = 15,
  parameter int unsigned MIN_RATIO = 1024,
  parameter int unsigned RST_RATIO = 1024
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               load_i,
  input  logic               apply_i,
  output logic [RATIO_W-1:0] pend_o,
  output logic [RATIO_W-1:0] act_o
);
  localparam logic [RATIO_W-1:0] FLOOR_VAL = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] RST_VAL   = RATIO_W'(RST_RATIO);

  logic [RATIO_W-1:0] floored;
  logic [RATIO_W-1:0] pend_q, pend_d;
  logic [RATIO_W-1:0] act_q, act_d;

  always_comb begin
    floored = (ratio_i < FLOOR_VAL) ? FLOOR_VAL : ratio_i;
    pend_d  = pend_q;
    act_d   = act_q;
    if (load_i)  pend_d = floored;
    if (apply_i) act_d  = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pend_q <= RST_VAL;
      act_q  <= RST_VAL;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/pswl_prescaler.sv
module pswl_prescaler
  import pswl_pkg::*;
#(
  parameter int unsigned SWALLOW_W = 5,
  parameter pswl_mod_e   RST_MOD   = MOD_BASE
) (
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  pswl_mod_e mod_next_i,
  output logic      tc_o
);
  localparam int unsigned        CNT_W      = SWALLOW_W + 1;
  localparam logic [CNT_W-1:0]   LOAD_BASE  = CNT_W'((1 << SWALLOW_W) - 1);
  localparam logic [CNT_W-1:0]   LOAD_EXTRA = CNT_W'(1 << SWALLOW_W);
  localparam logic [CNT_W-1:0]   LOAD_RST   = (RST_MOD == MOD_EXTRA) ? LOAD_EXTRA : LOAD_BASE;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tc;

  always_comb begin
    tc = (cnt_q == '0);
    if (tc) cnt_d = (mod_next_i == MOD_EXTRA) ? LOAD_EXTRA : LOAD_BASE;
    else    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= LOAD_RST;
    else          cnt_q <= cnt_d;
  end

  assign tc_o = tc;
endmodule

// File: rtl/pswl_swallow_ctrl.sv
module pswl_swallow_ctrl
  import pswl_pkg::*;
#(
  parameter int unsigned SWALLOW_W = 5,
  parameter int unsigned MAIN_W    = 10,
  parameter int unsigned RATIO_W   = SWALLOW_W + MAIN_W,
  parameter int unsigned RST_RATIO = 1024
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               tc_i,
  input  logic [RATIO_W-1:0] nxt_ratio_i,
  output pswl_mod_e          mod_next_o,
  output logic               period_end_o
);
  localparam logic [RATIO_W-1:0] RST_VEC  = RATIO_W'(RST_RATIO);
  localparam logic [MAIN_W-1:0]  MAIN_ONE = MAIN_W'(1);

  logic [SWALLOW_W-1:0] sw_q, sw_d;
  logic [MAIN_W-1:0]    main_q, main_d;
  logic                 period_end;

  always_comb begin
    period_end = tc_i && (main_q == MAIN_ONE);
    sw_d       = sw_q;
    main_d     = main_q;
    if (period_end) begin
      sw_d   = nxt_ratio_i[SWALLOW_W-1:0];
      main_d = nxt_ratio_i[RATIO_W-1:SWALLOW_W];
    end else if (tc_i) begin
      main_d = main_q - 1'b1;
      if (sw_q != '0) sw_d = sw_q - 1'b1;
    end
    // modulus of the prescaler cycle that starts after this one
    mod_next_o = (sw_d != '0) ? MOD_EXTRA : MOD_BASE;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sw_q   <= RST_VEC[SWALLOW_W-1:0];
      main_q <= RST_VEC[RATIO_W-1:SWALLOW_W];
    end else begin
      sw_q   <= sw_d;
      main_q <= main_d;
    end
  end

  assign period_end_o = period_end;
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider
  import pswl_pkg::*;
#(
  parameter  int unsigned SWALLOW_W   = PSWL_SWALLOW_W,
  parameter  int unsigned MAIN_W      = PSWL_MAIN_W,
  parameter  int unsigned RST_RATIO   = 1024,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned RATIO_W     = SWALLOW_W + MAIN_W
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               load_i,
  output logic               div_pulse_o
);
  // smallest ratio keeping the main count above every swallow count
  localparam int unsigned MIN_RATIO = 1 << (2 * SWALLOW_W);
  localparam int unsigned RST_EFF   = (RST_RATIO < MIN_RATIO) ? MIN_RATIO : RST_RATIO;
  localparam pswl_mod_e   RST_MOD   = ((RST_EFF % (1 << SWALLOW_W)) != 0) ? MOD_EXTRA : MOD_BASE;

  logic               rst_core_n;
  logic               pre_tc;
  logic               period_end;
  pswl_mod_e          mod_next;
  logic [RATIO_W-1:0] pend_ratio;
  logic [RATIO_W-1:0] act_ratio;
  logic               pulse_q;

  // reset: asserted at once, removed after SYNC_STAGES clock edges
  generate
    if (SYNC_STAGES <= 1) begin : g_sync_one
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= 1'b0;
        else          sync_q <= 1'b1;
      end
      assign rst_core_n = sync_q;
    end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_core_n = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  pswl_ratio_stage #(
    .RATIO_W  (RATIO_W),
    .MIN_RATIO(MIN_RATIO),
    .RST_RATIO(RST_EFF)
  ) u_ratio (
    .clk_i  (clk_i),
    .rst_n_i(rst_core_n),
    .ratio_i(ratio_i),
    .load_i (load_i),
    .apply_i(period_end),
    .pend_o (pend_ratio),
    .act_o  (act_ratio)
  );

  pswl_prescaler #(
    .SWALLOW_W(SWALLOW_W),
    .RST_MOD  (RST_MOD)
  ) u_presc (
    .clk_i     (clk_i),
    .rst_n_i   (rst_core_n),
    .mod_next_i(mod_next),
    .tc_o      (pre_tc)
  );

  pswl_swallow_ctrl #(
    .SWALLOW_W(SWALLOW_W),
    .MAIN_W   (MAIN_W),
    .RATIO_W  (RATIO_W),
    .RST_RATIO(RST_EFF)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_n_i     (rst_core_n),
    .tc_i        (pre_tc),
    .nxt_ratio_i (pend_ratio),
    .mod_next_o  (mod_next),
    .period_end_o(period_end)
  );

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n) pulse_q <= 1'b0;
    else             pulse_q <= period_end;
  end

  assign div_pulse_o = pulse_q;
endmodule

// File: rtl/pswl_divider_chk.sv
module pswl_divider_chk #(
  parameter int unsigned RATIO_W   = 15,
  parameter int unsigned SWALLOW_W = 5,
  parameter int unsigned MIN_RATIO = 1024
) (
  input logic               clk_i,
  input logic               rst_n_i,
  input logic               load_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               div_pulse_o,
  input logic               pre_tc,
  input logic               period_end,
  input logic [RATIO_W-1:0] pend_ratio,
  input logic [RATIO_W-1:0] act_ratio
);
  localparam int unsigned      GAP_W     = SWALLOW_W + 2;
  localparam logic [GAP_W-1:0] GAP_BASE  = GAP_W'(1 << SWALLOW_W);
  localparam logic [GAP_W-1:0] GAP_EXTRA = GAP_W'((1 << SWALLOW_W) + 1);
  localparam logic [RATIO_W-1:0] FLOOR_VAL = RATIO_W'(MIN_RATIO);

  logic [RATIO_W:0]   cyc_q;
  logic [RATIO_W:0]   per_q;
  logic               seen_q;
  logic [GAP_W-1:0]   gap_q;
  logic               tc_seen_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cyc_q     <= '0;
      per_q     <= '0;
      seen_q    <= 1'b0;
      gap_q     <= '0;
      tc_seen_q <= 1'b0;
    end else begin
      if (div_pulse_o) begin
        cyc_q  <= (RATIO_W+1)'(1);
        per_q  <= {1'b0, act_ratio};
        seen_q <= 1'b1;
      end else if (cyc_q != '1) begin
        cyc_q <= cyc_q + 1'b1;
      end
      if (pre_tc) begin
        gap_q     <= GAP_W'(1);
        tc_seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    div_pulse_o |=> !div_pulse_o);

  assert_period_len_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (div_pulse_o && seen_q) |-> (cyc_q == per_q));

  assert_presc_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (pre_tc && tc_seen_q) |-> ((gap_q == GAP_BASE) || (gap_q == GAP_EXTRA)));

  assert_hold_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !load_i |=> $stable(pend_ratio));

  assert_apply_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !period_end |=> $stable(act_ratio));

  assert_floor_load_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (load_i && (ratio_i < FLOOR_VAL)) |=> (pend_ratio == FLOOR_VAL));

  assert_floor_active_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    period_end |=> (act_ratio >= FLOOR_VAL));
endmodule

bind pswl_divider pswl_divider_chk #(
  .RATIO_W  (RATIO_W),
  .SWALLOW_W(SWALLOW_W),
  .MIN_RATIO(MIN_RATIO)
) u_pswl_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_core_n),
  .load_i     (load_i),
  .ratio_i    (ratio_i),
  .div_pulse_o(div_pulse_o),
  .pre_tc     (pre_tc),
  .period_end (period_end),
  .pend_ratio (pend_ratio),
  .act_ratio  (act_ratio)
);

// File: tb/tb_pswl_divider.sv
module tb_pswl_divider;
  logic        clk_i = 1'b0;
  logic        rst_n_i;
  logic [14:0] ratio_i;
  logic        load_i;
  logic        div_pulse_o;

  int checks = 0;
  int errors = 0;
  int cur_n;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pswl_divider dut (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .ratio_i    (ratio_i),
    .load_i     (load_i),
    .div_pulse_o(div_pulse_o)
  );

  function automatic int exp_ratio(input int r);
    return (r < 1024) ? 1024 : r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts falling edges until the pulse is seen; clears load after the first
  task automatic gap_to_pulse(output int n, output bit wide);
    n = 0;
    wide = 1'b0;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 1) begin
        load_i = 1'b0;
        if (div_pulse_o) wide = 1'b1;
      end
    end while (!div_pulse_o && n < 40000);
  endtask

  // called with a pulse high at the current falling edge
  task automatic load_and_measure(input int r, input string req);
    int g1, g2;
    bit w1, w2;
    ratio_i = 15'(r);
    load_i  = 1'b1;
    gap_to_pulse(g1, w1);
    check(!w1, "R2", int'(w1), 0);
    check(g1 == cur_n, {req, "/R6 old period"}, g1, cur_n);
    gap_to_pulse(g2, w2);
    check(!w2, "R2", int'(w2), 0);
    check(g2 == exp_ratio(r), {req, "/R3 new period"}, g2, exp_ratio(r));
    cur_n = exp_ratio(r);
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit w;
    int unsigned seed;
    seed    = $urandom(32'd4711);
    rst_n_i = 1'b0;
    load_i  = 1'b0;
    ratio_i = 15'd0;
    repeat (6) @(negedge clk_i);
    check(div_pulse_o == 1'b0, "R1 reset low", int'(div_pulse_o), 0);
    rst_n_i = 1'b1;

    // R1: first pulse after default ratio plus synchroniser delay
    gap_to_pulse(n, w);
    check(n == 1026, "R1 first pulse", n, 1026);
    cur_n = 1024;
    gap_to_pulse(n, w);
    check(n == 1024, "R3 default period", n, 1024);
    check(!w, "R2", int'(w), 0);

    // R5: ratio moves without load
    ratio_i = 15'd3000;
    gap_to_pulse(n, w);
    check(n == cur_n, "R5 no load", n, cur_n);
    ratio_i = 15'd1500;
    gap_to_pulse(n, w);
    check(n == cur_n, "R5 no load", n, cur_n);

    // R4 boundaries of the swallow count
    load_and_measure(1055, "R4 A=31");
    load_and_measure(1056, "R4 A=0");
    load_and_measure(2047, "R4 A=31 M=63");

    // R7 floor
    load_and_measure(5,    "R7 below floor");
    load_and_measure(2000, "R3");
    load_and_measure(0,    "R7 zero");
    load_and_measure(1023, "R7 just below");

    // R5: load value held after strobe while ratio keeps changing
    ratio_i = 15'd1300;
    load_i  = 1'b1;
    @(negedge clk_i);
    load_i  = 1'b0;
    ratio_i = 15'd2500;
    gap_to_pulse(n, w);
    check(n == cur_n - 1, "R6 old period", n, cur_n - 1);
    gap_to_pulse(n, w);
    check(n == 1300, "R5 captured value", n, 1300);
    cur_n = 1300;

    // R3 random ratios
    for (int i = 0; i < 8; i++) begin
      load_and_measure(int'($urandom_range(4095, 1024)), "R3 random");
    end

    // R3 upper end
    load_and_measure(32767, "R3 max");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule